// File: doc/BRIEF.md
# Dual-CPU Interrupt Status and Mask Router

This block collects a vector of level-style interrupt sources (32 or 64 of them) and presents them to up to two processors. For each processor it keeps a registered copy of the source status and a separate enable mask. It raises that processor's interrupt line while any source is both active and enabled. The mask is written over a plain 32-bit word bus. The bus also reads back status and mask. Multi-word vectors are stored with their words in reversed order.

A processor that wants to know which source to service pulses a request. One clock later the block answers with the chosen source index. The choice is not made by a fixed priority. Each processor owns a rotating pointer, and the search starts at the pointer and walks upward with wrap-around. After a successful pick the pointer moves just past the chosen source, so every source gets its turn. A contiguous band of source indices can be flagged as cascaded external lines, and an index inside that band is reported as an offset into the band. Dedicated mask and unmask commands update every present processor at once and honour a per-processor affinity vector. The second processor can be left out at elaboration time.

Top module: `irqc_top`

## Requirements
- R1: After reset every mask bit is 0, both interrupt lines are low, no selection is reported, and both rotating pointers are 0.
- R2: Bus address bit 2 selects the processor, bit 1 selects status (0) or mask (1), and bit 0 selects the word. Word w holds source (w XOR (WORDS-1))*32+b at bit b, so with 64 sources word 0 carries sources 32..63 and word 1 carries sources 0..31. Status reads return the source vector sampled one clock earlier.
- R3: A bus write to a mask address replaces that 32-bit slice of the mask in the following cycle. A write to a status address has no effect.
- R4: A processor's interrupt line is the OR of its status AND mask, registered, so it changes one clock after the status or mask register changes.
- R5: A selection request for a processor yields, one clock later, done=1, hit=1 and the first pending source found by scanning upward from that processor's pointer, modulo the source count.
- R6: After a hit the pointer becomes the chosen index plus one, modulo the source count. If nothing is pending, hit=0 and the pointer keeps its value.
- R7: Each processor has its own mask and its own pointer. A mask write or a selection for one processor leaves the other's unchanged.
- R8: A mask command clears the addressed source in every present processor's mask. An unmask command sets it where the affinity bit of that processor is 1 and clears it where the bit is 0.
- R9: When a bus mask write and a mask or unmask command hit the same cycle, the command decides the value of its own source bit. The bus write decides the other bits.
- R10: With cascading enabled, a hit on an index in CASC_LO..CASC_HI reports ext=1 and number=index-CASC_LO. Any other hit reports ext=0 and number=index.
- R11: With the second processor absent, its interrupt line stays low, its selections never complete, its addresses read 0, and writes to them have no effect.
- R12: With 32 sources the vector occupies word 0 alone, and word 1 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N | Level interrupt sources |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 3 | {processor, status/mask, word} |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| op_mask | input | 1 | Mask command for op_idx |
| op_unmask | input | 1 | Unmask command for op_idx |
| op_idx | input | IW | Source index for the command |
| op_aff | input | 2 | Per-processor affinity for unmask |
| sel_req | input | 2 | Selection request per processor |
| irq_o | output | 2 | Interrupt line per processor |
| sel_done_o | output | 2 | Selection answer valid |
| sel_hit_o | output | 2 | A pending source was found |
| sel_idx_o | output | 2*IW | Chosen raw index, processor c at [c*IW +: IW] |
| sel_ext_o | output | 2 | Chosen index lies in the cascaded band |
| sel_num_o | output | 2*IW | Reported number (band offset or raw index) |

## Verification
The bench builds two copies side by side on shared stimulus. The first has 64 sources, both processors, and cascading on over indices 40..43. It reaches the reversed two-word layout, the pointer wrap across the word boundary, both ends of the cascaded band, and affinity splitting between processors. The second has 32 sources, one processor and no cascading. It reaches the single-word layout, the unused word, and the absent-processor behaviour under the same bus traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_BITS = 32;
  localparam int ADDR_W    = 3;

  typedef enum logic {
    KIND_STAT = 1'b0,
    KIND_MASK = 1'b1
  } reg_kind_e;

  // slice base of bus word w for a vector spread over nwords words
  function automatic int word_base(input int w, input int nwords);
    return (w ^ (nwords - 1)) * WORD_BITS;
  endfunction
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  pend_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] cand;

  always_comb begin
    found_o = 1'b0;
    idx_o   = ptr_i;
    cand    = ptr_i;
    for (int k = 0; k < N; k++) begin
      cand = ptr_i + IW'(k);
      if (!found_o && pend_i[cand]) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int N     = 64,
  parameter int IW    = 6,
  parameter int WORDS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         src_i,
  input  logic                 wr_en,
  input  logic                 wr_word,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic                 op_clr,
  input  logic                 op_set,
  input  logic [IW-1:0]        op_idx,
  input  logic                 op_aff,
  input  logic                 req_i,
  output logic [N-1:0]         stat_o,
  output logic [N-1:0]         mask_o,
  output logic [N-1:0]         pend_o,
  output logic                 irq_o,
  output logic                 done_o,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0]  stat_q, mask_q, mask_d;
  logic [IW-1:0] ptr_q, ptr_d, idx_q, idx_d;
  logic          irq_q, done_q, hit_q;
  logic          found;
  logic [IW-1:0] pick;

  assign pend_o = stat_q & mask_q;

  irqc_pick #(.N(N), .IW(IW)) u_pick (
    .pend_i (pend_o),
    .ptr_i  (ptr_q),
    .found_o(found),
    .idx_o  (pick)
  );

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if (int'(wr_word) == w) mask_d[word_base(w, WORDS) +: WORD_BITS] = wr_data;
      end
    end
    if (op_clr)      mask_d[op_idx] = 1'b0;
    else if (op_set) mask_d[op_idx] = op_aff;
  end

  always_comb begin
    ptr_d = ptr_q;
    idx_d = idx_q;
    if (req_i && found) begin
      ptr_d = pick + IW'(1);
      idx_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      ptr_q  <= '0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      stat_q <= src_i;
      mask_q <= mask_d;
      irq_q  <= |pend_o;
      done_q <= req_i;
      hit_q  <= req_i & found;
      if (req_i) begin
        ptr_q <= ptr_d;
        idx_q <= idx_d;
      end
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
  assign done_o = done_q;
  assign hit_o  = hit_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N        = 64,
  parameter int HAS_CPU1 = 1,
  parameter int CASC_EN  = 1,
  parameter int CASC_LO  = 40,
  parameter int CASC_HI  = 43,
  localparam int IW      = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         src_i,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  input  logic                 op_mask,
  input  logic                 op_unmask,
  input  logic [IW-1:0]        op_idx,
  input  logic [1:0]           op_aff,
  input  logic [1:0]           sel_req,
  output logic [1:0]           irq_o,
  output logic [1:0]           sel_done_o,
  output logic [1:0]           sel_hit_o,
  output logic [2*IW-1:0]      sel_idx_o,
  output logic [1:0]           sel_ext_o,
  output logic [2*IW-1:0]      sel_num_o
);
  localparam int WORDS = N / WORD_BITS;

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic [N-1:0]  stat_a [2];
  logic [N-1:0]  mask_a [2];
  logic [N-1:0]  pend_a [2];
  logic [IW-1:0] idx_a  [2];
  logic [N-1:0]  rd_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  for (genvar c = 0; c < 2; c++) begin : g_cpu
    if (c == 0 || HAS_CPU1 != 0) begin : g_bank
      logic wr_en;
      assign wr_en = bus_we && (reg_kind_e'(bus_addr[1]) == KIND_MASK) && (int'(bus_addr[2]) == c);
      irqc_bank #(.N(N), .IW(IW), .WORDS(WORDS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .src_i  (src_i),
        .wr_en  (wr_en),
        .wr_word(bus_addr[0]),
        .wr_data(bus_wdata),
        .op_clr (op_mask),
        .op_set (op_unmask),
        .op_idx (op_idx),
        .op_aff (op_aff[c]),
        .req_i  (sel_req[c]),
        .stat_o (stat_a[c]),
        .mask_o (mask_a[c]),
        .pend_o (pend_a[c]),
        .irq_o  (irq_o[c]),
        .done_o (sel_done_o[c]),
        .hit_o  (sel_hit_o[c]),
        .idx_o  (idx_a[c])
      );
    end else begin : g_absent
      assign stat_a[c]     = '0;
      assign mask_a[c]     = '0;
      assign pend_a[c]     = '0;
      assign idx_a[c]      = '0;
      assign irq_o[c]      = 1'b0;
      assign sel_done_o[c] = 1'b0;
      assign sel_hit_o[c]  = 1'b0;
    end

    // cascade band mapping on the registered answer
    logic in_band;
    assign in_band = (CASC_EN != 0) && sel_hit_o[c] &&
                     (int'(idx_a[c]) >= CASC_LO) && (int'(idx_a[c]) <= CASC_HI);
    assign sel_ext_o[c]          = in_band;
    assign sel_idx_o[c*IW +: IW] = idx_a[c];
    assign sel_num_o[c*IW +: IW] = in_band ? (idx_a[c] - IW'(CASC_LO)) : idx_a[c];
  end

  always_comb begin
    rd_vec    = (reg_kind_e'(bus_addr[1]) == KIND_MASK) ? mask_a[bus_addr[2]] : stat_a[bus_addr[2]];
    bus_rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (int'(bus_addr[0]) == w) bus_rdata = rd_vec[word_base(w, WORDS) +: WORD_BITS];
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N    = 64,
  parameter int IW   = 6,
  parameter int SPAN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      sel_req,
  input logic [1:0]      done,
  input logic [1:0]      hit,
  input logic [1:0]      ext,
  input logic [IW-1:0]   idx0,
  input logic [IW-1:0]   idx1,
  input logic [2*IW-1:0] num,
  input logic [N-1:0]    pend0,
  input logic [N-1:0]    pend1,
  input logic [N-1:0]    mask0,
  input logic [N-1:0]    mask1,
  input logic            op_mask,
  input logic [IW-1:0]   op_idx
);
  logic [N-1:0] pend0_prev, pend1_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend0_prev <= '0;
      pend1_prev <= '0;
    end else begin
      pend0_prev <= pend0;
      pend1_prev <= pend1;
    end
  end

  assert_done_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done[0] |-> $past(sel_req[0]));
  assert_pick_was_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> pend0_prev[idx0]);
  assert_pick1_was_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |-> pend1_prev[idx1]);
  assert_empty_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && !hit[0]) |-> (pend0_prev == '0));
  assert_mask_cmd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_mask |=> (!mask0[$past(op_idx)] && !mask1[$past(op_idx)]));
  assert_ext_in_band_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext[0] |-> (hit[0] && (int'(num[IW-1:0]) <= SPAN)));
endmodule

bind irqc_top irqc_chk #(.N(N), .IW(IW), .SPAN(CASC_HI - CASC_LO)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .sel_req(sel_req),
  .done   (sel_done_o),
  .hit    (sel_hit_o),
  .ext    (sel_ext_o),
  .idx0   (idx_a[0]),
  .idx1   (idx_a[1]),
  .num    (sel_num_o),
  .pend0  (pend_a[0]),
  .pend1  (pend_a[1]),
  .mask0  (mask_a[0]),
  .mask1  (mask_a[1]),
  .op_mask(op_mask),
  .op_idx (op_idx)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, rdata_s;
  logic        op_m, op_u;
  logic [5:0]  op_idx;
  logic [1:0]  op_aff, req;
  logic [1:0]  irq, done, hit, ext, irq_s, done_s, hit_s, ext_s;
  logic [11:0] sidx, snum;
  logic [9:0]  sidx_s, snum_s;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irqc_top #(.N(64), .HAS_CPU1(1), .CASC_EN(1), .CASC_LO(40), .CASC_HI(43)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .op_mask(op_m), .op_unmask(op_u),
    .op_idx(op_idx), .op_aff(op_aff), .sel_req(req), .irq_o(irq),
    .sel_done_o(done), .sel_hit_o(hit), .sel_idx_o(sidx), .sel_ext_o(ext),
    .sel_num_o(snum));

  irqc_top #(.N(32), .HAS_CPU1(0), .CASC_EN(0), .CASC_LO(40), .CASC_HI(43)) dut_small (
    .clk(clk), .rst_n(rst_n), .src_i(src[31:0]), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_s), .op_mask(op_m), .op_unmask(op_u),
    .op_idx(op_idx[4:0]), .op_aff(op_aff), .sel_req(req), .irq_o(irq_s),
    .sel_done_o(done_s), .sel_hit_o(hit_s), .sel_idx_o(sidx_s), .sel_ext_o(ext_s),
    .sel_num_o(snum_s));

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    addr = a;
    #1;
  endtask

  task automatic set_src(input logic [63:0] v);
    src = v;
    @(negedge clk);
  endtask

  task automatic pick(input int c);
    req[c] = 1'b1;
    @(negedge clk);
    req[c] = 1'b0;
  endtask

  task automatic t_reset();
    bus_rd(3'b010); chk("R1 cpu0 mask w0", rdata, 0);
    bus_rd(3'b011); chk("R1 cpu0 mask w1", rdata, 0);
    bus_rd(3'b111); chk("R1 cpu1 mask w1", rdata, 0);
    chk("R1 irq lines", irq, 0);
    chk("R1 no selection", done, 0);
  endtask

  task automatic t_status();
    set_src(64'h1234_5678_9ABC_DEF0);
    bus_rd(3'b000); chk("R2 status word0 = high sources", rdata, 32'h1234_5678);
    bus_rd(3'b001); chk("R2 status word1 = low sources", rdata, 32'h9ABC_DEF0);
    bus_rd(3'b100); chk("R2 cpu1 status word0", rdata, 32'h1234_5678);
    chk("R12 small word0", rdata_s, 32'h0);
    bus_rd(3'b000); chk("R12 small word0 status", rdata_s, 32'h9ABC_DEF0);
    bus_rd(3'b001); chk("R12 small word1 reads 0", rdata_s, 32'h0);
    chk("R4 no irq with zero mask", irq, 0);
    set_src(64'h0);
    bus_wr(3'b000, 32'hFFFF_FFFF);
    bus_rd(3'b000); chk("R3 status write ignored", rdata, 32'h0);
  endtask

  task automatic t_irq();
    set_src(64'h20);
    bus_wr(3'b011, 32'h20);
    chk("R4 irq not yet", irq[0], 1'b0);
    @(negedge clk);
    chk("R4 irq one clock after mask", irq[0], 1'b1);
    chk("R7 cpu1 irq stays low", irq[1], 1'b0);
    chk("R12 small ignores word1 write", irq_s, 2'b00);
    bus_rd(3'b011); chk("R3 mask readback", rdata, 32'h20);
  endtask

  task automatic t_round_robin();
    bus_wr(3'b010, 32'hFFFF_FFFF);
    bus_wr(3'b011, 32'hFFFF_FFFF);
    bus_wr(3'b111, 32'hFFFF_FFFF);
    set_src(64'h0004_0000_0000_0408);
    pick(0);
    chk("R5 done", done[0], 1'b1);
    chk("R5 first pick", sidx[5:0], 6'd3);
    chk("R12 small first pick", sidx_s[4:0], 5'd3);
    pick(0); chk("R5 second pick", sidx[5:0], 6'd10);
    chk("R12 small second pick", sidx_s[4:0], 5'd10);
    pick(0); chk("R5 upper-word pick", sidx[5:0], 6'd50);
    pick(0); chk("R6 wrap pick", sidx[5:0], 6'd3);
    pick(1); chk("R7 cpu1 own pointer", sidx[11:6], 6'd3);
    chk("R11 absent cpu1 no done", done_s[1], 1'b0);
  endtask

  task automatic t_cascade();
    set_src(64'h1 << 41);
    pick(0);
    chk("R10 ext in band", ext[0], 1'b1);
    chk("R10 band offset", snum[5:0], 6'd1);
    set_src(64'h1 << 40);
    pick(0);
    chk("R10 band low edge idx", sidx[5:0], 6'd40);
    chk("R10 band low edge num", snum[5:0], 6'd0);
    set_src(64'h1 << 44);
    pick(0);
    chk("R10 outside band ext", ext[0], 1'b0);
    chk("R10 outside band num", snum[5:0], 6'd44);
  endtask

  task automatic t_empty();
    set_src(64'h0);
    pick(0);
    chk("R6 empty done", done[0], 1'b1);
    chk("R6 empty no hit", hit[0], 1'b0);
    set_src((64'h1 << 45) | (64'h1 << 30));
    pick(0);
    chk("R6 pointer kept", sidx[5:0], 6'd45);
  endtask

  task automatic t_ops();
    op_u = 1'b1; op_idx = 6'd7; op_aff = 2'b10;
    @(negedge clk);
    op_u = 1'b0;
    bus_rd(3'b011); chk("R8 unmask clears cpu0", rdata, 32'hFFFF_FF7F);
    bus_rd(3'b111); chk("R8 unmask sets cpu1", rdata, 32'hFFFF_FFFF);
    bus_rd(3'b010); chk("R8 small unmask clears", rdata_s, 32'hFFFF_FF7F);
    op_m = 1'b1; op_idx = 6'd8;
    @(negedge clk);
    op_m = 1'b0;
    bus_rd(3'b111); chk("R8 mask clears cpu1", rdata, 32'hFFFF_FEFF);
    bus_rd(3'b011); chk("R8 mask clears cpu0", rdata, 32'hFFFF_FE7F);
  endtask

  task automatic t_conflict();
    op_m = 1'b1; op_idx = 6'd33;
    bus_wr(3'b110, 32'hFFFF_FFFF);
    op_m = 1'b0;
    bus_rd(3'b110); chk("R9 command wins its bit", rdata, 32'hFFFF_FFFD);
  endtask

  task automatic t_absent();
    bus_wr(3'b110, 32'h0000_FFFF);
    set_src(64'hFFFF);
    @(negedge clk);
    bus_rd(3'b110); chk("R11 absent cpu1 reads 0", rdata_s, 32'h0);
    bus_rd(3'b100); chk("R11 absent cpu1 status 0", rdata_s, 32'h0);
    chk("R11 absent cpu1 irq low", irq_s[1], 1'b0);
    pick(1);
    chk("R11 absent cpu1 never done", done_s[1], 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; we = 1'b0; addr = '0; wdata = '0;
    op_m = 1'b0; op_u = 1'b0; op_idx = '0; op_aff = '0; req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status();
    t_irq();
    t_round_robin();
    t_cascade();
    t_empty();
    t_ops();
    t_conflict();
    t_absent();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule